// File: doc/BRIEF.md
# Adaptive Stride Prefetcher

The prefetcher sits beside a second-level cache and observes every data miss it reports. Each miss event carries an identifier of the access stream, typically the address of the instruction that missed, and the byte address that missed. A small direct-mapped history table, indexed by the low identifier bits, remembers for each stream:

- the last miss address;
- the last stride;
- the last change of stride;
- a pattern mode;
- a saturating confidence count.

From that history the block recognises two kinds of stream:

- a constant stride;
- a stride that grows or shrinks by the same amount on every miss.

Once a stream is trusted, the block emits line-aligned prefetch addresses on a valid/ready output. The confidence count decides how many lines ahead are requested for each trigger.

Misses are accepted on every cycle and never stalled. Processing passes through three registered steps: lookup, predict/update and issue. Back-to-back misses of one stream see their own latest history through a forwarding path. Requests wait in an 8-entry queue while the consumer is busy, and requests that find the queue full are discarded.

Top module: `stride_prefetcher`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pf_valid` is low. Reset empties the request queue and invalidates every history entry, so the first miss of a stream after reset issues no prefetch.
- R2: A miss whose distance from the stream's previous miss equals the stored stride, with that stride nonzero, classifies the stream as fixed. In fixed mode the k-th request of a burst is the line of `miss_addr + k*stride`, for k = 1 to the degree.
- R3: The stride delta is the current stride minus the previous stride. Once two strides are known, a miss whose stride delta equals the stored nonzero delta classifies the stream as linear. In linear mode the k-th request adds a stride that has grown by k deltas to the (k-1)-th address, with the miss address as the 0-th.
- R4: Confidence is a 3-bit count. It is set to 1 when the classification changes mode, and it rises by one (stopping at 7) when the classification repeats the current mode. When the classification finds no pattern, confidence falls by one (stopping at 0) and the mode is kept.
- R5: The number of requests per trigger is 0 for confidence 0-1, 1 for 2-3, 2 for 4-5 and 4 for 6-7. A stream with no mode issues none.
- R6: The table has 16 entries, selected by `miss_id[3:0]`, and the tag is `miss_id[15:4]`. On a tag mismatch the entry is replaced and its history is cleared, and no request is issued for that miss. Entries at other indices are untouched.
- R7: Every request is the 64-byte line address (`pf_addr[5:0]` = 0). A candidate whose line equals the triggering miss's line, or the line of an earlier candidate of the same burst, is not issued.
- R8: A miss sampled at clock edge n can first raise `pf_valid` after edge n+2. Misses on consecutive cycles, including ones of the same stream, all update the history in arrival order.
- R9: While `pf_ready` is low, `pf_valid` and `pf_addr` hold. Up to 8 requests wait in first-in first-out order, and candidates beyond the free space present at that cycle are dropped.
- R10: Dropping requests never stalls or alters miss processing. The history keeps learning, so the next trigger after the queue drains issues according to the confidence reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss event is present this cycle |
| miss_id | input | 16 | Stream identifier of the miss |
| miss_addr | input | 32 | Byte address that missed |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Consumer takes the offered request |
| pf_addr | output | 32 | Line-aligned prefetch address |

## Verification
The checker assumes that reset is held for at least two consecutive cycles. With that assumption, the only way for `pf_valid` to fall is a handshake. It also assumes that `pf_ready` is the only reason a request waits. The stimulus always holds reset for three cycles and changes `miss_valid`, `miss_id`, `miss_addr` and `pf_ready` only shortly after a rising edge. The stimulus drives misses either one per cycle or separated by long idle gaps, so the expected request stream of every phase can be worked out in order, including the phase where the queue overflows on purpose.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int ID_W    = 16;
    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 4;
    localparam int LINE_B  = 6;
    localparam int CONF_W  = 3;
    localparam int MAX_DEG = 4;
    localparam int TAG_W   = ID_W - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_FIXED  = 2'd1,
        MODE_LINEAR = 2'd2
    } mode_e;

    typedef struct packed {
        logic               valid;
        logic [TAG_W-1:0]   tag;
        logic [ADDR_W-1:0]  last;
        logic [ADDR_W-1:0]  stride;
        logic [ADDR_W-1:0]  delta;
        logic [1:0]         hist;   // 0: address only, 1: stride known, 2: delta known
        mode_e              mode;
        logic [CONF_W-1:0]  conf;
    } entry_t;

    function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:LINE_B], {LINE_B{1'b0}}};
    endfunction

    function automatic logic [2:0] degree_of(input logic [CONF_W-1:0] c);
        case (c[CONF_W-1:CONF_W-2])
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/spf_table.sv
module spf_table
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output entry_t            rd_entry,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_t            wr_entry
);
    entry_t slots [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/spf_predict.sv
module spf_predict
    import spf_pkg::*;
(
    input  logic                            s_valid,
    input  logic [TAG_W-1:0]                s_tag,
    input  logic [ADDR_W-1:0]               s_addr,
    input  entry_t                          cur,
    output entry_t                          nxt,
    output logic [MAX_DEG-1:0]              cand_ok,
    output logic [MAX_DEG-1:0][ADDR_W-1:0]  cand_line
);
    logic              hit;
    logic [ADDR_W-1:0] new_stride, new_delta, inc;
    mode_e             cls;
    logic [2:0]        deg;

    always_comb begin
        hit        = cur.valid && (cur.tag == s_tag);
        new_stride = s_addr - cur.last;
        new_delta  = new_stride - cur.stride;

        cls = MODE_NONE;
        if (hit && cur.hist != 2'd0) begin
            if (new_stride == cur.stride && new_stride != '0)
                cls = MODE_FIXED;
            else if (cur.hist == 2'd2 && new_delta == cur.delta && cur.delta != '0)
                cls = MODE_LINEAR;
        end

        nxt = cur;
        if (!hit) begin
            nxt       = '0;
            nxt.valid = 1'b1;
            nxt.tag   = s_tag;
            nxt.last  = s_addr;
        end else begin
            nxt.last   = s_addr;
            nxt.stride = new_stride;
            nxt.delta  = (cur.hist != 2'd0) ? new_delta : '0;
            nxt.hist   = (cur.hist == 2'd2) ? 2'd2 : cur.hist + 2'd1;
            if (cur.hist != 2'd0) begin
                if (cls != MODE_NONE && cls != cur.mode) begin
                    nxt.mode = cls;
                    nxt.conf = CONF_W'(1);
                end else if (cls != MODE_NONE) begin
                    if (cur.conf != CONF_MAX) nxt.conf = cur.conf + CONF_W'(1);
                end else if (cur.conf != '0) begin
                    nxt.conf = cur.conf - CONF_W'(1);
                end
            end
        end

        deg = (hit && nxt.mode != MODE_NONE) ? degree_of(nxt.conf) : 3'd0;
        inc = (nxt.mode == MODE_LINEAR) ? nxt.delta : '0;
    end

    logic [MAX_DEG-1:0][ADDR_W-1:0] step, reach;

    for (genvar k = 0; k < MAX_DEG; k++) begin : g_chain
        if (k == 0) begin : g_first
            assign step[k]  = nxt.stride + inc;
            assign reach[k] = s_addr + step[k];
        end else begin : g_next
            assign step[k]  = step[k-1] + inc;
            assign reach[k] = reach[k-1] + step[k];
        end
        assign cand_line[k] = line_of(reach[k]);

        logic dup;
        always_comb begin
            dup = (cand_line[k] == line_of(s_addr));
            for (int j = 0; j < k; j++)
                if (cand_line[j] == cand_line[k]) dup = 1'b1;
        end
        assign cand_ok[k] = s_valid && (3'(k) < deg) && !dup;
    end
endmodule

// File: rtl/spf_queue.sv
module spf_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    parameter int N     = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        in_ok,
    input  logic [N-1:0][W-1:0] in_addr,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [W-1:0]        out_addr
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]       slots [DEPTH];
    logic [PW-1:0]      rd_ptr, wr_ptr;
    logic [PW:0]        count, free, n_take;
    logic [N-1:0][PW:0] rank;
    logic [N-1:0]       take;
    logic               pop;

    always_comb begin
        free   = (PW+1)'(DEPTH) - count;
        n_take = '0;
        for (int k = 0; k < N; k++) begin
            rank[k] = n_take;
            take[k] = in_ok[k] && (rank[k] < free);
            if (take[k]) n_take = n_take + (PW+1)'(1);
        end
    end

    assign out_valid = (count != '0);
    assign out_addr  = slots[rd_ptr];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++)
            if (take[k]) slots[wr_ptr + rank[k][PW-1:0]] <= in_addr[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + n_take[PW-1:0];
            rd_ptr <= rd_ptr + PW'(pop);
            count  <= count + n_take - (PW+1)'(pop);
        end
    end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
    import spf_pkg::*;
#(
    parameter int QUEUE_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ID_W-1:0]   miss_id,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    // stage 1: lookup
    logic              s1_v;
    logic [ID_W-1:0]   s1_id;
    logic [ADDR_W-1:0] s1_addr;
    entry_t            s1_ent;
    entry_t            rd_entry, upd_entry;
    logic              fwd;

    // stage 2 -> 3
    logic [MAX_DEG-1:0]             c_ok, s3_ok;
    logic [MAX_DEG-1:0][ADDR_W-1:0] c_line, s3_line;

    spf_table u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (miss_id[IDX_W-1:0]),
        .rd_entry (rd_entry),
        .wr_en    (s1_v),
        .wr_idx   (s1_id[IDX_W-1:0]),
        .wr_entry (upd_entry)
    );

    // an update in flight for the same index wins over the stale table copy
    assign fwd = s1_v && (s1_id[IDX_W-1:0] == miss_id[IDX_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v    <= 1'b0;
            s1_id   <= '0;
            s1_addr <= '0;
            s1_ent  <= '0;
        end else begin
            s1_v    <= miss_valid;
            s1_id   <= miss_id;
            s1_addr <= miss_addr;
            s1_ent  <= fwd ? upd_entry : rd_entry;
        end
    end

    spf_predict u_predict (
        .s_valid   (s1_v),
        .s_tag     (s1_id[ID_W-1:IDX_W]),
        .s_addr    (s1_addr),
        .cur       (s1_ent),
        .nxt       (upd_entry),
        .cand_ok   (c_ok),
        .cand_line (c_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_ok   <= '0;
            s3_line <= '0;
        end else begin
            s3_ok   <= c_ok;
            s3_line <= c_line;
        end
    end

    spf_queue #(
        .DEPTH (QUEUE_DEPTH),
        .W     (ADDR_W),
        .N     (MAX_DEG)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .in_ok     (s3_ok),
        .in_addr   (s3_line),
        .out_valid (pf_valid),
        .out_ready (pf_ready),
        .out_addr  (pf_addr)
    );
endmodule

// File: rtl/spf_checker.sv
module spf_checker
    import spf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    // R9
    drain_only_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pf_valid) |-> $past(pf_ready));

    // R7
    line_align_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr[LINE_B-1:0] == '0));

    // R8
    issue_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_valid) |-> $past(miss_valid, 3));
endmodule

bind stride_prefetcher spf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr)
);

// File: tb/stride_prefetcher_tb.sv
module stride_prefetcher_tb;
    import spf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic [15:0] miss_id = '0;
    logic [31:0] miss_addr = '0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [31:0] pf_addr;

    always #10 clk = ~clk;

    stride_prefetcher u_dut (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_id    (miss_id),
        .miss_addr  (miss_addr),
        .pf_valid   (pf_valid),
        .pf_ready   (pf_ready),
        .pf_addr    (pf_addr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] id;
        logic [31:0] addr;
        logic [2:0]  n;
        logic [31:0] e0, e1, e2, e3;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0005, 32'h1000, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1080, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1100, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1180, 3'd1, 32'h1200, 32'h0, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1200, 3'd1, 32'h1280, 32'h0, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1280, 3'd2, 32'h1300, 32'h1380, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1300, 3'd2, 32'h1380, 32'h1400, 32'h0, 32'h0},
        '{2'd0, 16'h0005, 32'h1380, 3'd4, 32'h1400, 32'h1480, 32'h1500, 32'h1580},
        '{2'd0, 16'h0005, 32'h1400, 3'd4, 32'h1480, 32'h1500, 32'h1580, 32'h1600},
        '{2'd0, 16'h0005, 32'h1480, 3'd4, 32'h1500, 32'h1580, 32'h1600, 32'h1680},
        '{2'd3, 16'h0005, 32'h2000, 3'd4, 32'h2B80, 32'h3700, 32'h4280, 32'h4E00},
        '{2'd1, 16'h0003, 32'h10000, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd1, 16'h0003, 32'h10040, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd1, 16'h0003, 32'h100C0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd1, 16'h0003, 32'h10180, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd1, 16'h0003, 32'h10280, 3'd1, 32'h103C0, 32'h0, 32'h0, 32'h0},
        '{2'd1, 16'h0003, 32'h103C0, 3'd1, 32'h10540, 32'h0, 32'h0, 32'h0},
        '{2'd1, 16'h0003, 32'h10540, 3'd2, 32'h10700, 32'h10900, 32'h0, 32'h0},
        '{2'd2, 16'h0007, 32'h20000, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd2, 16'h0007, 32'h20020, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd2, 16'h0007, 32'h20040, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd2, 16'h0007, 32'h20060, 3'd1, 32'h20080, 32'h0, 32'h0, 32'h0},
        '{2'd2, 16'h0007, 32'h20080, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{2'd2, 16'h0007, 32'h200A0, 3'd1, 32'h200C0, 32'h0, 32'h0, 32'h0}
    };

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] obs  [128];
    logic [31:0] expv [128];
    int          obs_n = 0;
    int          exp_n = 0;
    int          seen  = 0;
    logic [31:0] held;

    // record every accepted request
    always @(negedge clk) begin
        if (!rst && pf_valid && pf_ready && obs_n < 128) begin
            obs[obs_n] = pf_addr;
            obs_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic miss(input logic [15:0] id, input logic [31:0] a);
        @(posedge clk); #2;
        miss_valid = 1'b1;
        miss_id    = id;
        miss_addr  = a;
    endtask

    task automatic idle(input int n);
        @(posedge clk); #2;
        miss_valid = 1'b0;
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic push_exp(input logic [31:0] a);
        if (exp_n < 128) begin
            expv[exp_n] = a;
            exp_n++;
        end
    endtask

    task automatic verify(input string req);
        chk(obs_n == exp_n, {req, " request count"}, 32'(obs_n), 32'(exp_n));
        for (int i = seen; i < exp_n; i++)
            chk(i < obs_n && obs[i] === expv[i], req, (i < obs_n) ? obs[i] : 32'hxxxxxxxx, expv[i]);
        exp_n = obs_n;
        seen  = obs_n;
    endtask

    function automatic string kind_name(input logic [1:0] k);
        case (k)
            2'd0:    return "R2 R5 fixed stride";
            2'd1:    return "R3 linear stride";
            2'd2:    return "R7 line dedup";
            default: return "R4 confidence decrement";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #5;
        // R1 reset state
        chk(pf_valid == 1'b0, "R1 idle after reset", 32'(pf_valid), 32'd0);

        // table of vectors: fixed, linear, dedup streams
        for (int i = 0; i < NV; i++) begin
            miss(VECS[i].id, VECS[i].addr);
            if (VECS[i].n > 3'd0) push_exp(VECS[i].e0);
            if (VECS[i].n > 3'd1) push_exp(VECS[i].e1);
            if (VECS[i].n > 3'd2) push_exp(VECS[i].e2);
            if (VECS[i].n > 3'd3) push_exp(VECS[i].e3);
            idle(8);
            verify(kind_name(VECS[i].kind));
        end

        // R6 aliasing identifier replaces index 5
        miss(16'h0015, 32'h5000);
        idle(8);
        verify("R6 alias allocates");
        miss(16'h0005, 32'h1500);
        idle(8);
        verify("R6 replaced history cleared");
        miss(16'h0003, 32'h10700);
        push_exp(32'h10900);
        push_exp(32'h10B40);
        idle(8);
        verify("R6 other index intact");

        // R8 back-to-back misses of one stream
        miss(16'h0009, 32'h3000);
        miss(16'h0009, 32'h3040);
        miss(16'h0009, 32'h3080);
        miss(16'h0009, 32'h30C0);
        miss(16'h0009, 32'h3100);
        push_exp(32'h3100);
        push_exp(32'h3140);
        idle(10);
        verify("R8 back-to-back forwarding");

        // R9 stall and overflow
        @(posedge clk); #2 pf_ready = 1'b0;
        for (int i = 0; i < 10; i++)
            miss(16'h000B, 32'h40000 + 32'(i) * 32'h1000);
        idle(10);
        chk(pf_valid == 1'b1, "R9 request held while stalled", 32'(pf_valid), 32'd1);
        chk(pf_addr == 32'h44000, "R9 oldest request at head", pf_addr, 32'h44000);
        chk(obs_n == exp_n, "R9 nothing consumed while stalled", 32'(obs_n), 32'(exp_n));
        held = pf_addr;
        idle(3);
        chk(pf_addr == held, "R9 head stable", pf_addr, held);
        @(posedge clk); #2 pf_ready = 1'b1;
        push_exp(32'h44000);
        push_exp(32'h45000);
        push_exp(32'h46000);
        push_exp(32'h47000);
        push_exp(32'h47000);
        push_exp(32'h48000);
        push_exp(32'h48000);
        push_exp(32'h49000);
        idle(12);
        verify("R9 queue keeps eight and drops the rest");
        chk(pf_valid == 1'b0, "R9 queue drained", 32'(pf_valid), 32'd0);

        // R10 learning continued through the drops
        miss(16'h000B, 32'h4A000);
        push_exp(32'h4B000);
        push_exp(32'h4C000);
        push_exp(32'h4D000);
        push_exp(32'h4E000);
        idle(8);
        verify("R10 confidence kept during drops");

        // R1 reset clears queue and table
        @(posedge clk); #2 pf_ready = 1'b0;
        miss(16'h0003, 32'h10900);
        idle(6);
        chk(pf_valid == 1'b1, "R1 requests pending before reset", 32'(pf_valid), 32'd1);
        @(posedge clk); #2 rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #5;
        chk(pf_valid == 1'b0, "R1 reset empties queue", 32'(pf_valid), 32'd0);
        exp_n = obs_n;
        seen  = obs_n;
        @(posedge clk); #2 pf_ready = 1'b1;
        miss(16'h0003, 32'h10B40);
        idle(8);
        verify("R1 history invalidated by reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule